// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Detection

This block is the receive half of an asynchronous serial port. It watches a single input line that idles high, looks at it once per oversample tick (sixteen ticks per bit period), finds the falling edge of a start bit and confirms it at mid-bit. It then gathers eight data bits, least significant first, an optional parity bit, and a stop bit. Characters that arrive intact are written into a 32-entry queue. Software drains the queue one entry per read strobe and sees the oldest entry at the data output at all times.

Errors are reported as single-cycle event pulses. A stop bit sampled low gives a frame error, and a wrong parity bit gives a parity error. A write into a full queue gives an overflow. A held-low line is reported in two ways: it produces a frame error at every character time, and it produces a single break event once a selectable number of consecutive all-low characters has been seen. The tick source, the baud divider and any register interface are outside this block.

Top module: `uart_rx_top`

## Requirements
- R1: With reception enabled, a low line seen on a tick starts a frame. The start bit is confirmed by a low sample 8 ticks later, and every following bit is sampled 16 ticks after the one before it. Data bits arrive least significant bit first, and an intact character is stored in the queue.
- R2: The queue is first-in first-out with 32 entries. `rd_data_o` shows the oldest entry, each `rd_i` cycle on a non-empty queue removes one entry, and `level_o` counts the stored entries from 0 to 32.
- R3: When `par_en_i` is 1, a parity bit follows the data. With `par_odd_i`=0 the expected bit is the XOR of the eight data bits, and with `par_odd_i`=1 it is the inverse of that XOR. On a mismatch `parity_err_o` pulses and the character is not stored.
- R4: A stop bit sampled as 0 pulses `frame_err_o`, and the character is not stored.
- R5: With parity off, an all-zero frame whose stop bit is low is a frame error. With even parity on, a zero byte with parity bit 0 and a high stop bit is ordinary data and is stored.
- R6: An intact character that arrives while 32 entries are stored is discarded. `overflow_o` pulses and `level_o` stays at 32.
- R7: `wm_o` is 1 exactly when `level_o` is greater than or equal to `wm_lvl_i`.
- R8: A held-low line gives a frame error at every character time. `break_o` pulses once, one cycle after the N-th consecutive all-low character, where N is 2, 4, 8 or 16 for `brk_lvl_i` = 0, 1, 2 or 3. Frame errors keep coming after the break.
- R9: After a break, no further break is reported until the line has been sampled high on a tick. After that, a new held-low period can raise a new break.
- R10: While `rx_en_i` is 0 the receiver stays idle. Line activity stores nothing and raises no event.
- R11: A low pulse that has ended before the mid-bit confirmation point is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line; idles high |
| tick_i | input | 1 | Oversample tick, one cycle wide, 16 per bit |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| brk_lvl_i | input | 2 | Break length select: 2, 4, 8 or 16 characters |
| wm_lvl_i | input | 6 | Watermark threshold |
| rd_i | input | 1 | Pop one entry from the queue |
| rd_data_o | output | 8 | Oldest queued byte |
| level_o | output | 6 | Number of queued bytes |
| wm_o | output | 1 | Level at or above threshold |
| frame_err_o | output | 1 | Frame error pulse |
| parity_err_o | output | 1 | Parity error pulse |
| break_o | output | 1 | Break detected pulse |
| overflow_o | output | 1 | Character dropped on a full queue |

## Verification
The bench holds the line low and counts frame errors one character at a time. A receiver that counted the break threshold off by one, or raised the break on every later character, would show its break pulse too early, too late or more than once. The bench also releases the line and lowers it again, which catches a detector that never re-arms. A short low glitch is sent to catch a receiver that trusts the edge and skips the mid-bit check. A zero byte is sent with even parity to catch a design that confuses data with a break or inverts the parity sense. The queue is filled to 32 and one more character is sent; a queue that wraps would overwrite its oldest entry, and a queue that saturates wrongly would lose the first byte read back.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned BRK_SEL_W = 2;
    localparam int unsigned BRK_CNT_W = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    // Number of consecutive all-low characters that makes a break.
    function automatic logic [BRK_CNT_W-1:0] brk_target(input logic [BRK_SEL_W-1:0] sel);
        return BRK_CNT_W'(2) << sel;
    endfunction

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              en_i,
    input  logic              par_en_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bit_o,
    output logic              stop_o
);

    localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam int unsigned HALF  = OVERSAMPLE / 2;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  os;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              stop;
        logic              done;
    } framer_t;

    framer_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!en_i) begin
            st_d.st = RX_IDLE;
            st_d.os = '0;
        end else if (tick_i) begin
            unique case (st_q.st)
                RX_IDLE: begin
                    if (!line_i) begin
                        st_d.st = RX_START;
                        st_d.os = '0;
                    end
                end
                RX_START: begin
                    st_d.os = st_q.os + CNT_W'(1);
                    if (st_q.os == HALF_LAST) begin
                        st_d.os = '0;
                        if (!line_i) begin
                            st_d.st  = RX_DATA;
                            st_d.idx = '0;
                            st_d.par = 1'b0;
                        end else begin
                            st_d.st = RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    st_d.os = st_q.os + CNT_W'(1);
                    if (st_q.os == FULL_LAST) begin
                        st_d.os  = '0;
                        st_d.sh  = {line_i, st_q.sh[DATA_W-1:1]};
                        st_d.idx = st_q.idx + IDX_W'(1);
                        if (st_q.idx == IDX_LAST) begin
                            st_d.st = par_en_i ? RX_PAR : RX_STOP;
                        end
                    end
                end
                RX_PAR: begin
                    st_d.os = st_q.os + CNT_W'(1);
                    if (st_q.os == FULL_LAST) begin
                        st_d.os  = '0;
                        st_d.par = line_i;
                        st_d.st  = RX_STOP;
                    end
                end
                RX_STOP: begin
                    st_d.os = st_q.os + CNT_W'(1);
                    if (st_q.os == FULL_LAST) begin
                        st_d.os   = '0;
                        st_d.stop = line_i;
                        st_d.done = 1'b1;
                        st_d.st   = RX_IDLE;
                    end
                end
                default: st_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{st: RX_IDLE, os: '0, idx: '0, sh: '0, par: 1'b0, stop: 1'b1, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign data_o    = st_q.sh;
    assign par_bit_o = st_q.par;
    assign stop_o    = st_q.stop;

endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
    import uart_rx_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 line_i,
    input  logic                 frame_done_i,
    input  logic                 frame_bad_i,
    input  logic                 frame_zero_i,
    input  logic [BRK_SEL_W-1:0] lvl_i,
    output logic                 break_o
);

    typedef struct packed {
        logic [BRK_CNT_W-1:0] cnt;
        logic                 armed;
        logic                 brk;
    } brk_t;

    brk_t b_d, b_q;
    logic [BRK_CNT_W-1:0] target;

    always_comb begin
        target  = brk_target(lvl_i);
        b_d     = b_q;
        b_d.brk = 1'b0;
        if (tick_i && line_i) begin
            b_d.cnt   = '0;
            b_d.armed = 1'b1;
        end
        if (frame_done_i && frame_bad_i && frame_zero_i) begin
            if (b_q.cnt != target) begin
                b_d.cnt = b_q.cnt + BRK_CNT_W'(1);
            end
            if (b_q.armed && (b_q.cnt + BRK_CNT_W'(1) == target)) begin
                b_d.brk   = 1'b1;
                b_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            b_q <= '{cnt: '0, armed: 1'b1, brk: 1'b0};
        end else begin
            b_q <= b_d;
        end
    end

    assign break_o = b_q.brk;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [CW-1:0]    level_o,
    output logic             overflow_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic full, empty, do_push, do_pop;

    always_comb begin
        full    = (p_q.cnt == FULL_CNT);
        empty   = (p_q.cnt == '0);
        do_push = push_i && !full;
        do_pop  = pop_i && !empty;
        p_d     = p_q;
        if (do_push) begin
            p_d.wp = (p_q.wp == LAST_PTR) ? '0 : p_q.wp + AW'(1);
        end
        if (do_pop) begin
            p_d.rp = (p_q.rp == LAST_PTR) ? '0 : p_q.rp + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + CW'(1);
            2'b01:   p_d.cnt = p_q.cnt - CW'(1);
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) begin
            mem_q[p_q.wp] <= wdata_i;
        end
    end

    assign rdata_o    = mem_q[p_q.rp];
    assign level_o    = p_q.cnt;
    assign overflow_o = push_i && full;

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned OVERSAMPLE = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_i,
    input  logic                 tick_i,
    input  logic                 rx_en_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    input  logic [BRK_SEL_W-1:0] brk_lvl_i,
    input  logic [CW-1:0]        wm_lvl_i,
    input  logic                 rd_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [CW-1:0]        level_o,
    output logic                 wm_o,
    output logic                 frame_err_o,
    output logic                 parity_err_o,
    output logic                 break_o,
    output logic                 overflow_o
);

    logic [1:0] sync_d, sync_q;
    logic line;

    always_comb begin
        sync_d = {sync_q[0], rx_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign line = sync_q[1];

    logic              done, par_bit, stop;
    logic [DATA_W-1:0] data;
    logic              par_bad, push, frame_zero;

    uart_rx_framer #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_framer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .line_i   (line),
        .en_i     (rx_en_i),
        .par_en_i (par_en_i),
        .done_o   (done),
        .data_o   (data),
        .par_bit_o(par_bit),
        .stop_o   (stop)
    );

    always_comb begin
        par_bad    = par_en_i && (par_bit != ((^data) ^ par_odd_i));
        push       = done && stop && !par_bad;
        frame_zero = (data == '0) && !par_bit;
    end

    assign frame_err_o  = done && !stop;
    assign parity_err_o = done && par_bad;

    uart_rx_break u_break (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .line_i      (line),
        .frame_done_i(done),
        .frame_bad_i (!stop),
        .frame_zero_i(frame_zero),
        .lvl_i       (brk_lvl_i),
        .break_o     (break_o)
    );

    uart_rx_fifo #(
        .DEPTH(DEPTH),
        .WIDTH(DATA_W)
    ) u_fifo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (push),
        .wdata_i   (data),
        .pop_i     (rd_i),
        .rdata_o   (rd_data_o),
        .level_o   (level_o),
        .overflow_o(overflow_o)
    );

    assign wm_o = (level_o >= wm_lvl_i);

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          rd_i,
    input logic [CW-1:0] level_o,
    input logic          frame_err_o,
    input logic          parity_err_o,
    input logic          break_o,
    input logic          overflow_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    assert_frame_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_err_o && !rd_i) |=> $stable(level_o));

    assert_parity_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (parity_err_o && !rd_i) |=> $stable(level_o));

    assert_no_overflow_below_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (level_o == FULL_CNT));

    assert_overflow_only_good_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (!frame_err_o && !parity_err_o));

    assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= FULL_CNT);

    assert_level_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == $past(level_o)) || (level_o == $past(level_o) + CW'(1)) ||
        (level_o + CW'(1) == $past(level_o)));

    assert_break_follows_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_o |-> $past(frame_err_o));

    assert_break_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_o |=> !break_o);

endmodule

bind uart_rx_top uart_rx_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_rx_top_bench.sv
module uart_rx_top_bench;

    localparam int DEPTH = 32;
    localparam int CW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          tick = 1'b0;
    logic          en = 1'b1;
    logic          pen = 1'b0;
    logic          podd = 1'b0;
    logic [1:0]    blvl = 2'd0;
    logic [CW-1:0] wml = CW'(4);
    logic          rd = 1'b0;

    logic [7:0]    rd_data;
    logic [CW-1:0] level;
    logic          wm, fe, pe, brk, ov;

    int vectors = 0;
    int miscompares = 0;
    int fe_cnt = 0, pe_cnt = 0, brk_cnt = 0, ov_cnt = 0;
    bit done_flag = 0;

    uart_rx_top #(.DEPTH(DEPTH)) u_uart_rx_top (
        .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .rx_en_i(en),
        .par_en_i(pen), .par_odd_i(podd), .brk_lvl_i(blvl), .wm_lvl_i(wml),
        .rd_i(rd), .rd_data_o(rd_data), .level_o(level), .wm_o(wm),
        .frame_err_o(fe), .parity_err_o(pe), .break_o(brk), .overflow_o(ov)
    );

    always #2.5ns clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (fe)  fe_cnt++;
        if (pe)  pe_cnt++;
        if (brk) brk_cnt++;
        if (ov)  ov_cnt++;
    end

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
    endtask

    task automatic drive(logic v, int n);
        @(negedge clk);
        rx = v;
        ticks(n);
    endtask

    task automatic send(logic [7:0] data, bit with_par, bit par_val, bit stop_ok);
        drive(1'b0, 16);
        for (int i = 0; i < 8; i++) drive(data[i], 16);
        if (with_par) drive(par_val, 16);
        if (stop_ok) drive(1'b1, 16);
        else begin
            drive(1'b0, 12);
            drive(1'b1, 4);
        end
        drive(1'b1, 4);
        @(negedge clk);
    endtask

    task automatic pop_expect(string req, int exp);
        @(negedge clk);
        check(req, "rd_data", rd_data, exp);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset;
        check("R2", "level after reset", level, 0);
        check("R7", "wm after reset", wm, 0);
        check("R4", "no frame event after reset", fe_cnt, 0);
    endtask

    task automatic t_basic;
        send(8'hA5, 0, 0, 1);
        send(8'h3C, 0, 0, 1);
        check("R1", "level after two chars", level, 2);
        check("R1", "no frame error", fe_cnt, 0);
        pop_expect("R1", 8'hA5);
        pop_expect("R2", 8'h3C);
        @(negedge clk);
        check("R2", "level after drain", level, 0);
    endtask

    task automatic t_parity;
        int pe0;
        pe0 = pe_cnt;
        pen = 1'b1;
        podd = 1'b0;
        send(8'h00, 1, 0, 1);
        check("R5", "zero byte with even parity stored", level, 1);
        check("R5", "no frame error on zero byte", fe_cnt, 0);
        send(8'h07, 1, 1, 1);
        check("R3", "even parity good stored", level, 2);
        send(8'h07, 1, 0, 1);
        check("R3", "parity error count", pe_cnt, pe0 + 1);
        check("R3", "bad parity not stored", level, 2);
        podd = 1'b1;
        send(8'h07, 1, 0, 1);
        check("R3", "odd parity good stored", level, 3);
        send(8'h81, 1, 0, 1);
        check("R3", "odd parity error count", pe_cnt, pe0 + 2);
        pop_expect("R5", 8'h00);
        pop_expect("R3", 8'h07);
        pop_expect("R3", 8'h07);
        pen = 1'b0;
        podd = 1'b0;
    endtask

    task automatic t_frame;
        int fe0;
        fe0 = fe_cnt;
        send(8'h55, 0, 0, 0);
        check("R4", "frame error count", fe_cnt, fe0 + 1);
        check("R4", "bad frame not stored", level, 0);
        send(8'h00, 0, 0, 0);
        check("R5", "all-zero no parity is frame error", fe_cnt, fe0 + 2);
        check("R5", "all-zero no parity not stored", level, 0);
        check("R8", "short low gives no break", brk_cnt, 0);
    endtask

    task automatic t_overflow;
        wml = CW'(4);
        for (int i = 0; i < DEPTH; i++) begin
            send(8'(i + 1), 0, 0, 1);
            if (i == 2) check("R7", "wm below threshold", wm, 0);
            if (i == 3) check("R7", "wm at threshold", wm, 1);
        end
        check("R6", "level full", level, DEPTH);
        check("R6", "no overflow yet", ov_cnt, 0);
        send(8'hEE, 0, 0, 1);
        check("R6", "overflow count", ov_cnt, 1);
        check("R6", "level stays full", level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_expect("R6", i + 1);
        @(negedge clk);
        check("R2", "level after full drain", level, 0);
        check("R7", "wm after drain", wm, 0);
    endtask

    task automatic t_disable;
        int fe0;
        fe0 = fe_cnt;
        en = 1'b0;
        send(8'h11, 0, 0, 1);
        send(8'h00, 0, 0, 0);
        en = 1'b1;
        ticks(4);
        @(negedge clk);
        check("R10", "disabled stores nothing", level, 0);
        check("R10", "disabled raises no frame error", fe_cnt, fe0);
    endtask

    task automatic t_glitch;
        int fe0;
        fe0 = fe_cnt;
        drive(1'b0, 4);
        drive(1'b1, 200);
        @(negedge clk);
        check("R11", "glitch stores nothing", level, 0);
        check("R11", "glitch raises no frame error", fe_cnt, fe0);
    endtask

    task automatic t_break;
        int fe0, b0;
        blvl = 2'd0;
        fe0 = fe_cnt;
        b0 = brk_cnt;
        @(negedge clk);
        rx = 1'b0;
        wait (fe_cnt == fe0 + 1);
        repeat (4) @(negedge clk);
        check("R8", "no break after first low char", brk_cnt, b0);
        wait (fe_cnt == fe0 + 2);
        repeat (4) @(negedge clk);
        check("R8", "break after second low char", brk_cnt, b0 + 1);
        wait (fe_cnt == fe0 + 5);
        @(negedge clk);
        check("R9", "break raised only once", brk_cnt, b0 + 1);
        rx = 1'b1;
        ticks(40);
        @(negedge clk);
        check("R8", "frame errors every char time", fe_cnt, fe0 + 5);
        check("R8", "held low stores nothing", level, 0);

        fe0 = fe_cnt;
        b0 = brk_cnt;
        rx = 1'b0;
        wait (fe_cnt == fe0 + 2);
        repeat (4) @(negedge clk);
        check("R9", "break re-armed after line high", brk_cnt, b0 + 1);
        rx = 1'b1;
        ticks(40);

        blvl = 2'd1;
        fe0 = fe_cnt;
        b0 = brk_cnt;
        @(negedge clk);
        rx = 1'b0;
        wait (fe_cnt == fe0 + 3);
        repeat (4) @(negedge clk);
        check("R8", "level 4 not reached at 3 chars", brk_cnt, b0);
        wait (fe_cnt == fe0 + 4);
        repeat (4) @(negedge clk);
        check("R8", "level 4 break at fourth char", brk_cnt, b0 + 1);
        rx = 1'b1;
        ticks(40);
        @(negedge clk);
        check("R8", "level after break test", level, 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_parity();
        t_frame();
        t_disable();
        t_glitch();
        t_overflow();
        t_break();
        done_flag = 1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule